// File: doc/BRIEF.md
# BLDC commutation and blanking controller

This block sequences one sensorless brushless DC motor. Software stages the next six-bit gate pattern and a commutation period through a small register write port. A free-running commutation counter moves both into use in a single step each time it expires. Between commutations, one gate output that the pattern selects is chopped by an internal PWM counter. All other enabled gates stay steadily on.

The block also drives a sample-valid flag for the back-EMF ADC path. Two one-shot windows pull this flag low. The first opens on every transition of the PWM waveform and covers switching ringing. The second opens on every commutation and covers the decay of phase current. Dead-time insertion, speed regulation and the converter itself sit outside the block.

Top module: `bldc_comm_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no writes, all six gate outputs are 0 and `sample_ok` is 1.
- R2: The commutation counter is COMM_W bits wide (32 by default). With an active period P it expires once every P+1 clock cycles, and every bit of P is honoured, including bit 31.
- R3: A write to address 0 stages a pattern. Bits [5:0] enable the gates in the order A-high, A-low, B-high, B-low, C-high, C-low (bit 0 first). Bits [8:6] give the index of the chopped gate. The staged pattern reaches the outputs in one step when the counter expires.
- R4: A pattern written at address 0, or a period written at address 1, while a period is running has no effect on the outputs until the next expiry.
- R5: Only the gate whose index equals the chop field follows the PWM waveform, ANDed with its enable bit. Every other gate equals its enable bit. A chop index of 6 or 7 chops no gate.
- R6: The PWM counter runs from 0 to the value at address 2 and wraps, and the waveform is high while the count is below the duty at address 3. Both registers take effect at once. With PWM_W=10, a period of 500 counts at duty 250 gives exactly 250 high cycles.
- R7: Each PWM transition opens a ringing window of L cycles (L from address 4), starting with the transition cycle. L=0 disables the window. A transition inside an open window restarts it at full length.
- R8: Each commutation opens a decay window of K cycles (K from address 5), starting with the cycle in which the new pattern appears. K=0 disables the window.
- R9: `sample_ok` is 0 exactly while either window is open, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 pattern, 1 commutation period, 2 PWM period, 3 duty, 4 ringing length, 5 decay length |
| wr_data | input | COMM_W | Write data, low bits used for narrow registers |
| gate_out | output | 6 | Gate drives, A-high in bit 0 to C-low in bit 5 |
| sample_ok | output | 1 | High when ADC results may be used |

## Verification
The bench builds the block with COMM_W=32, PWM_W=10, BLK_W=8 and CBLK_W=12. The 10-bit PWM counter brings a 500-count period into reach, so duty resolution can be measured at its intended size. The full 32-bit commutation counter allows a period with bit 31 set to be shown holding the pattern far beyond any short wrap. The 8-bit ringing length permits a window longer than the gap between PWM edges, which exposes the restart rule.

// File: rtl/bldc_comm_ctrl.sv
module bldc_comm_ctrl #(
  parameter int COMM_W = 32,
  parameter int PWM_W  = 10,
  parameter int BLK_W  = 8,
  parameter int CBLK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [COMM_W-1:0] wr_data,
  output logic [5:0]        gate_out,
  output logic              sample_ok
);

  logic [COMM_W-1:0] comm_cnt, comm_per, comm_per_nxt;
  logic [5:0]        pat_act, pat_nxt;
  logic [2:0]        sel_act, sel_nxt;
  logic [PWM_W-1:0]  pwm_cnt, pwm_per, pwm_duty;
  logic [BLK_W-1:0]  pblk_len, pblk_cnt;
  logic [CBLK_W-1:0] cblk_len, cblk_cnt;
  logic              pwm_on_q;

  wire comm_ovf = (comm_cnt == comm_per);
  wire pwm_on   = (pwm_cnt < pwm_duty);
  wire pblk_hit = (pwm_on ^ pwm_on_q) && (pblk_len != '0);

  assign sample_ok = !pblk_hit && (pblk_cnt == '0) && (cblk_cnt == '0);

  for (genvar g = 0; g < 6; g++) begin : g_gate
    assign gate_out[g] = pat_act[g] & ((sel_act == 3'(g)) ? pwm_on : 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_nxt      <= '0;
      sel_nxt      <= '0;
      comm_per_nxt <= '0;
      pwm_per      <= '0;
      pwm_duty     <= '0;
      pblk_len     <= '0;
      cblk_len     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin
          pat_nxt <= wr_data[5:0];
          sel_nxt <= wr_data[8:6];
        end
        3'd1: comm_per_nxt <= wr_data;
        3'd2: pwm_per      <= wr_data[PWM_W-1:0];
        3'd3: pwm_duty     <= wr_data[PWM_W-1:0];
        3'd4: pblk_len     <= wr_data[BLK_W-1:0];
        3'd5: cblk_len     <= wr_data[CBLK_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comm_cnt <= '0;
      comm_per <= '0;
      pat_act  <= '0;
      sel_act  <= '0;
    end else if (comm_ovf) begin
      comm_cnt <= '0;
      comm_per <= comm_per_nxt;
      pat_act  <= pat_nxt;
      sel_act  <= sel_nxt;
    end else begin
      comm_cnt <= comm_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_cnt  <= '0;
      pwm_on_q <= 1'b0;
      pblk_cnt <= '0;
      cblk_cnt <= '0;
    end else begin
      pwm_cnt  <= (pwm_cnt >= pwm_per) ? '0 : pwm_cnt + 1'b1;
      pwm_on_q <= pwm_on;
      if (pblk_hit)
        pblk_cnt <= pblk_len - 1'b1;
      else if (pblk_cnt != '0)
        pblk_cnt <= pblk_cnt - 1'b1;
      if (comm_ovf)
        cblk_cnt <= cblk_len;
      else if (cblk_cnt != '0)
        cblk_cnt <= cblk_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/bldc_comm_ctrl_chk.sv
module bldc_comm_ctrl_chk #(
  parameter int BLK_W  = 8,
  parameter int CBLK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              comm_ovf,
  input logic [5:0]        pat_act,
  input logic [5:0]        pat_nxt,
  input logic [2:0]        sel_act,
  input logic [5:0]        gate_out,
  input logic              pwm_on,
  input logic [BLK_W-1:0]  pblk_len,
  input logic [CBLK_W-1:0] cblk_len,
  input logic [CBLK_W-1:0] cblk_cnt,
  input logic              sample_ok
);

  logic [5:0] sel_mask;
  assign sel_mask = 6'b1 << sel_act;

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    comm_ovf |=> (pat_act == $past(pat_nxt)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !comm_ovf |=> $stable(pat_act));

  p_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((gate_out ^ pat_act) & ~sel_mask) == 6'b0));

  p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_out & ~pat_act) == 6'b0));

  p_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_on != $past(pwm_on)) && (pblk_len != '0)) |-> !sample_ok);

  p_decay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (comm_ovf && (cblk_len != '0)) |=> !sample_ok);

  p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cblk_cnt != '0) |-> !sample_ok);

endmodule

bind bldc_comm_ctrl bldc_comm_ctrl_chk #(.BLK_W(BLK_W), .CBLK_W(CBLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .comm_ovf(comm_ovf), .pat_act(pat_act),
  .pat_nxt(pat_nxt), .sel_act(sel_act), .gate_out(gate_out), .pwm_on(pwm_on),
  .pblk_len(pblk_len), .cblk_len(cblk_len), .cblk_cnt(cblk_cnt),
  .sample_ok(sample_ok)
);

// File: tb/bldc_comm_ctrl_tb.sv
module bldc_comm_ctrl_tb;
  localparam int CW = 32;
  localparam int PW = 10;
  localparam int BW = 8;
  localparam int KW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [CW-1:0] wr_data;
  logic [5:0]    gate_out;
  logic          sample_ok;

  always #5 clk = ~clk;

  bldc_comm_ctrl #(.COMM_W(CW), .PWM_W(PW), .BLK_W(BW), .CBLK_W(KW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gate_out(gate_out), .sample_ok(sample_ok)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model state
  logic [CW-1:0] m_cnt, m_per, m_per_n;
  logic [5:0]    m_pat, m_pat_n;
  int m_sel, m_sel_n, m_pc, m_pper, m_duty, m_plen, m_clen, m_pb, m_cb;
  bit m_onq;

  always @(posedge clk) begin : mdl
    bit ovf, on, edg;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_per_n = 0; m_pat = 0; m_pat_n = 0;
      m_sel = 0; m_sel_n = 0; m_pc = 0; m_pper = 0; m_duty = 0;
      m_plen = 0; m_clen = 0; m_pb = 0; m_cb = 0; m_onq = 0;
    end else begin
      ovf = (m_cnt == m_per);
      on  = (m_pc < m_duty);
      edg = (on != m_onq);
      if (edg && m_plen != 0) m_pb = m_plen - 1;
      else if (m_pb > 0) m_pb--;
      if (ovf) m_cb = m_clen;
      else if (m_cb > 0) m_cb--;
      if (ovf) begin
        m_cnt = 0; m_per = m_per_n; m_pat = m_pat_n; m_sel = m_sel_n;
      end else m_cnt = m_cnt + 1;
      m_onq = on;
      m_pc = (m_pc >= m_pper) ? 0 : m_pc + 1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_pat_n = wr_data[5:0]; m_sel_n = int'(wr_data[8:6]); end
          3'd1: m_per_n = wr_data;
          3'd2: m_pper = int'(wr_data[PW-1:0]);
          3'd3: m_duty = int'(wr_data[PW-1:0]);
          3'd4: m_plen = int'(wr_data[BW-1:0]);
          3'd5: m_clen = int'(wr_data[KW-1:0]);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin : cmp
    bit on;
    logic [5:0] eg;
    bit eo;
    if (rst_n && !done) begin
      on = (m_pc < m_duty);
      for (int i = 0; i < 6; i++)
        eg[i] = m_pat[i] && ((i == m_sel) ? on : 1'b1);
      eo = !(((on != m_onq) && m_plen != 0) || m_pb > 0 || m_cb > 0);
      chk(gate_out == eg, "R3 R5 gate_out vs model", gate_out, eg);
      chk(sample_ok == eo, "R7 R8 R9 sample_ok vs model", sample_ok, eo);
    end
  end

  task automatic wr(input int a, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_low(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!sample_ok) c++;
    end
  endtask

  initial begin
    int n, c0, c2;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(gate_out == 6'h00, "R1 gate_out in reset", gate_out, 0);
    chk(sample_ok == 1'b1, "R1 sample_ok in reset", sample_ok, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gate_out == 6'h00, "R1 gate_out after reset", gate_out, 0);
    chk(sample_ok == 1'b1, "R1 sample_ok after reset", sample_ok, 1);

    // commutation interval, pattern with no chop
    wr(5, 1);
    wr(0, (7 << 6) | 6'h05);
    wr(1, 7);
    repeat (30) @(negedge clk);
    chk(gate_out == 6'h05, "R3 pattern applied", gate_out, 5);
    while (sample_ok) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (sample_ok && n < 100);
    chk(n == 8, "R2 expiry interval for period 7", n, 8);

    // staging: now just after an expiry
    wr(0, (7 << 6) | 6'h2A);
    chk(gate_out == 6'h05, "R4 pattern held mid-period", gate_out, 5);
    repeat (11) @(negedge clk);
    chk(gate_out == 6'h2A, "R4 pattern applied at expiry", gate_out, 42);

    // decay window length
    wr(5, 4);
    wr(1, 9);
    repeat (40) @(negedge clk);
    count_low(10, n);
    chk(n == 4, "R8 decay window cycles per period", n, 4);

    // PWM resolution and single chopped gate
    wr(5, 0);
    wr(4, 0);
    wr(0, (2 << 6) | 6'h05);
    wr(1, 999);
    wr(2, 499);
    wr(3, 250);
    repeat (60) @(negedge clk);
    c0 = 0; c2 = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (gate_out[0]) c0++;
      if (gate_out[2]) c2++;
    end
    chk(c2 == 250, "R6 chopped gate high cycles", c2, 250);
    chk(c0 == 500, "R5 unchopped gate steady", c0, 500);

    // ringing windows
    wr(2, 49);
    wr(3, 20);
    wr(4, 6);
    repeat (200) @(negedge clk);
    count_low(50, n);
    chk(n == 12, "R7 ringing cycles per PWM period", n, 12);
    wr(4, 30);
    repeat (200) @(negedge clk);
    count_low(50, n);
    chk(n == 50, "R7 restart on edge inside window", n, 50);
    wr(4, 0);
    repeat (50) @(negedge clk);
    count_low(50, n);
    chk(n == 0, "R9 no window gives sample_ok high", n, 0);

    // long period: bit 31 honoured
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wr(0, (7 << 6) | 6'h03);
    wr(1, 32'h8000_0005);
    wr(0, (7 << 6) | 6'h30);
    repeat (300) @(negedge clk);
    chk(gate_out == 6'h03, "R2 no expiry with bit 31 period", gate_out, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule